// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one down-counting timer channel. It steps on a slow timer tick taken from the system clock by a fixed divider. The default divide ratio of 12 matches a 14.31818 MHz reference feeding a timer that counts at about 1.19318 MHz, which is roughly 838 ns per count. Software loads a mode bit and a 16-bit initial count. From then on the channel produces a periodic waveform on its output pin, and the rising edge of that waveform serves downstream as an edge-triggered interrupt request once per period.

There are two waveforms. In rate mode the counter steps down by one per tick and reloads on its own, and the output drops low for exactly one tick in each period. In square mode the counter steps down by two and the output flips at each terminal count, so the output toggles with a period equal to the loaded count. A gate input freezes the channel. A latch strobe copies the live count into a holding register, which gives a stable elapsed-time reading without disturbing the count.

Top module: `interval_timer_chan`

## Requirements
- R1: After synchronous reset the output is high, the readback value is 0, and the channel stays idle until the first load: the count does not move and the output stays high.
- R2: In rate mode (ld_mode = 0) the count drops by one on each timer tick. When it would pass 1 it reloads the loaded value. Rising edges of the output are therefore N ticks apart for a loaded count N of 2 or more.
- R3: In rate mode the output is low for exactly one timer tick per period, while the count is 1, and high at all other times.
- R4: In square mode (ld_mode = 1) the count drops by two per tick. The output period is N ticks. For even N the low part lasts N/2 ticks. For odd N the high part lasts one tick longer than the low part, so the low part lasts (N-1)/2 ticks.
- R5: A loaded count of 0 stands for 65536. Readback shows 0 right after such a load, and after two further ticks in rate mode it shows 65534.
- R6: While gate is 0 the count and the output hold their values. When gate returns to 1, counting resumes from the held value.
- R7: A load takes effect at the next clock edge. The count restarts from the new value, the output goes high, and the new mode applies. A load wins over a timer tick or terminal count that falls in the same cycle.
- R8: A latch strobe captures the count as it stands at that clock edge, before any update made at the same edge. The readback port keeps this value until the next strobe.
- R9: Timer ticks occur once every DIV clock cycles, so every tick-based duration above lasts that many ticks times DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gate | input | 1 | 1 lets the channel count, 0 freezes it |
| ld_valid | input | 1 | Load strobe for mode and count |
| ld_mode | input | 1 | 0 = rate mode, 1 = square mode |
| ld_count | input | CNT_W | Initial count; 0 means 2^CNT_W |
| latch_strobe | input | 1 | Capture the live count for readback |
| rd_count | output | CNT_W | Last captured count |
| tmr_out | output | 1 | Timer output waveform |

## Verification
A load and a terminal-count reload can fall in the same cycle, and the two compete for the counter. The bench waits for the rate-mode output to fall. It then places a load of a different count exactly one tick period later, on the edge where the automatic reload would happen. It latches the count on the next cycle. The reading must equal the newly loaded count rather than the old reload value, and the output must be high. A latch that coincides with a tick is covered by fixed-spacing latch pairs, whose difference must equal the exact number of ticks between them.

// File: rtl/itc_pkg.sv
package itc_pkg;
  localparam int CNT_W_DEF = 16;
  localparam int DIV_DEF   = 12;

  typedef enum logic {
    MODE_RATE   = 1'b0,
    MODE_SQUARE = 1'b1
  } tmr_mode_e;
endpackage

// File: rtl/itc_prescale.sv
module itc_prescale #(
  parameter int DIV = itc_pkg::DIV_DEF
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase;

      always_ff @(posedge clk) begin
        if (rst)                phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + PW'(1);
      end

      assign tick = (phase == LAST);

      // R9: ticks never come back to back when dividing
      assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick) else $error("tick repeated on adjacent cycles");
    end
  endgenerate
endmodule

// File: rtl/itc_core.sv
module itc_core #(
  parameter int CNT_W = itc_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             gate,
  input  logic             ld_valid,
  input  logic             ld_mode,
  input  logic [CNT_W-1:0] ld_count,
  output logic [CNT_W-1:0] cnt_lo,
  output logic             out_o
);
  import itc_pkg::*;

  localparam int VW = CNT_W + 1;
  localparam logic [VW-1:0] K1 = VW'(1);
  localparam logic [VW-1:0] K2 = VW'(2);

  // count value 0 stands for the full range
  function automatic logic [VW-1:0] full_count(input logic [CNT_W-1:0] c);
    return (c == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, c};
  endfunction

  // square mode: high half rounded up to even, low half rounded down
  function automatic logic [VW-1:0] hi_reload(input logic [VW-1:0] n);
    return n + {{CNT_W{1'b0}}, n[0]};
  endfunction

  function automatic logic [VW-1:0] lo_reload(input logic [VW-1:0] n);
    return n - {{CNT_W{1'b0}}, n[0]};
  endfunction

  logic [VW-1:0]    cnt;
  logic [CNT_W-1:0] init;
  tmr_mode_e        mode;
  logic             armed;
  logic             out_q;

  logic [VW-1:0] nval;
  logic [VW-1:0] rate_next;
  logic          step;
  logic          tc_evt;
  tmr_mode_e     ld_mode_e;

  assign ld_mode_e = tmr_mode_e'(ld_mode);
  assign nval      = full_count(init);
  assign step      = tick && gate && armed;
  assign tc_evt    = step && ((mode == MODE_RATE) ? (cnt == K1) : (cnt <= K2));
  assign rate_next = tc_evt ? nval : (cnt - K1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      init  <= '0;
      mode  <= MODE_RATE;
      armed <= 1'b0;
      out_q <= 1'b1;
    end else if (ld_valid) begin
      init  <= ld_count;
      mode  <= ld_mode_e;
      armed <= 1'b1;
      out_q <= 1'b1;
      cnt   <= (ld_mode_e == MODE_SQUARE) ? hi_reload(full_count(ld_count))
                                          : full_count(ld_count);
    end else if (step) begin
      if (mode == MODE_RATE) begin
        cnt   <= rate_next;
        out_q <= (rate_next != K1);
      end else if (tc_evt) begin
        out_q <= ~out_q;
        cnt   <= out_q ? lo_reload(nval) : hi_reload(nval);
      end else begin
        cnt <= cnt - K2;
      end
    end
  end

  assign cnt_lo = cnt[CNT_W-1:0];
  assign out_o  = out_q;

  // R1: an idle channel holds a zero count and a high output
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (out_q && cnt == '0)) else $error("idle channel not quiet");

  // R3: rate terminal count reloads and releases the pulse
  assert_rate_reload_R3: assert property (@(posedge clk) disable iff (rst)
    (tc_evt && mode == MODE_RATE && !ld_valid) |=> (out_q && cnt == $past(nval)))
    else $error("rate reload wrong");

  // R4: square mode count stays even
  assert_square_even_R4: assert property (@(posedge clk) disable iff (rst)
    (armed && mode == MODE_SQUARE) |-> !cnt[0]) else $error("odd square count");

  // R6: gate low freezes the channel
  assert_gate_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (armed && !gate && !ld_valid) |=> ($stable(cnt) && $stable(out_q)))
    else $error("count moved with gate low");

  // R7: a load arms the channel, raises the output and sets the mode
  assert_load_restart_R7: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> (out_q && armed && mode == $past(ld_mode_e)))
    else $error("load did not restart");
endmodule

// File: rtl/itc_readback.sv
module itc_readback #(
  parameter int CNT_W = itc_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic [CNT_W-1:0] cnt_in,
  output logic [CNT_W-1:0] rd_o
);
  logic [CNT_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst)         hold <= '0;
    else if (strobe) hold <= cnt_in;
  end

  assign rd_o = hold;

  // R8: captured value is the count present at the strobe edge
  assert_latch_capture_R8: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (rd_o == $past(cnt_in))) else $error("latch missed count");

  // R8: without a strobe the readback is stable
  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(rd_o)) else $error("readback drifted");
endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan #(
  parameter int DIV   = itc_pkg::DIV_DEF,
  parameter int CNT_W = itc_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate,
  input  logic             ld_valid,
  input  logic             ld_mode,
  input  logic [CNT_W-1:0] ld_count,
  input  logic             latch_strobe,
  output logic [CNT_W-1:0] rd_count,
  output logic             tmr_out
);
  logic             tick_w;
  logic [CNT_W-1:0] cnt_w;

  itc_prescale #(.DIV(DIV)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick_w)
  );

  itc_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_w),
    .gate     (gate),
    .ld_valid (ld_valid),
    .ld_mode  (ld_mode),
    .ld_count (ld_count),
    .cnt_lo   (cnt_w),
    .out_o    (tmr_out)
  );

  itc_readback #(.CNT_W(CNT_W)) u_rb (
    .clk    (clk),
    .rst    (rst),
    .strobe (latch_strobe),
    .cnt_in (cnt_w),
    .rd_o   (rd_count)
  );
endmodule

// File: tb/sim_interval_timer_chan.sv
module sim_interval_timer_chan;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gate = 1'b1;
  logic        ld_valid = 1'b0;
  logic        ld_mode = 1'b0;
  logic [15:0] ld_count = '0;
  logic        latch_strobe = 1'b0;
  logic [15:0] rd_count;
  logic        tmr_out;

  interval_timer_chan #(.DIV(DIV), .CNT_W(16)) u0 (
    .clk(clk), .rst(rst), .gate(gate), .ld_valid(ld_valid), .ld_mode(ld_mode),
    .ld_count(ld_count), .latch_strobe(latch_strobe), .rd_count(rd_count),
    .tmr_out(tmr_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard of expected waveform periods
  typedef struct {
    int    per;
    int    low;
    string tag;
  } exp_t;
  exp_t sb_q[$];
  int   skip = 0;
  logic prev_out = 1'b1;
  int   last_rise = 0;
  int   last_fall = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_out === 1'b0 && tmr_out === 1'b1) begin
        if (skip > 0) skip--;
        else if (sb_q.size() > 0) begin
          exp_t e;
          e = sb_q.pop_front();
          check({e.tag, " period"}, cyc - last_rise, e.per);
          check({e.tag, " low"}, cyc - last_fall, e.low);
        end
        last_rise = cyc;
      end
      if (prev_out === 1'b1 && tmr_out === 1'b0) last_fall = cyc;
      prev_out = tmr_out;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  // load, then latch on the following cycle and return the reading
  task automatic load_latch(logic m, logic [15:0] n, output logic [15:0] v);
    @(posedge clk); #1;
    ld_valid = 1'b1; ld_mode = m; ld_count = n;
    sb_q.delete();
    skip = (tmr_out == 1'b0) ? 2 : 1;
    @(posedge clk); #1;
    ld_valid = 1'b0; latch_strobe = 1'b1;
    @(posedge clk); #1;
    latch_strobe = 1'b0;
    @(negedge clk);
    v = rd_count;
  endtask

  task automatic latch_now(output logic [15:0] v);
    @(posedge clk); #1;
    latch_strobe = 1'b1;
    @(posedge clk); #1;
    latch_strobe = 1'b0;
    @(negedge clk);
    v = rd_count;
  endtask

  task automatic run_periods(logic m, int n, int k, string tag);
    int per = n * DIV;
    int low = m ? ((n - (n % 2)) / 2) * DIV : DIV;
    int t = 0;
    for (int i = 0; i < k; i++) begin
      exp_t e;
      e.per = per; e.low = low; e.tag = tag;
      sb_q.push_back(e);
    end
    while (sb_q.size() > 0 && t < (k + 3) * per + 50) begin
      @(negedge clk);
      t++;
    end
    check({tag, " timeout"}, sb_q.size(), 0);
  endtask

  initial begin
    logic [15:0] a, b;
    wait_cyc(4); #1; rst = 1'b0;
    @(negedge clk);
    check("R1 out after reset", int'(tmr_out), 1);
    latch_now(a);
    check("R1 readback after reset", int'(a), 0);
    wait_cyc(20);
    latch_now(a);
    check("R1 idle count", int'(a), 0);
    check("R1 idle out", int'(tmr_out), 1);

    // rate mode waveforms
    load_latch(1'b0, 16'd5, a);
    check("R7 restart value", int'(a), 5);
    run_periods(1'b0, 5, 4, "R2 R3 R9 rate N=5");
    load_latch(1'b0, 16'd2, a);
    run_periods(1'b0, 2, 4, "R2 R3 rate N=2");

    // square mode waveforms
    load_latch(1'b1, 16'd6, a);
    run_periods(1'b1, 6, 3, "R4 square N=6");
    load_latch(1'b1, 16'd7, a);
    run_periods(1'b1, 7, 3, "R4 square N=7");
    load_latch(1'b1, 16'd2, a);
    run_periods(1'b1, 2, 3, "R4 square N=2");

    // readback step sizes: latches 3*DIV apart
    load_latch(1'b0, 16'd1000, a);
    latch_now(a); wait_cyc(3 * DIV - 2); latch_now(b);
    check("R2 step by one", int'(a) - int'(b), 3);
    wait_cyc(20);
    check("R8 readback held", int'(rd_count), int'(b));
    load_latch(1'b1, 16'd1000, a);
    latch_now(a); wait_cyc(3 * DIV - 2); latch_now(b);
    check("R4 step by two", int'(a) - int'(b), 6);

    // gate freeze and resume
    load_latch(1'b0, 16'd1000, a);
    @(posedge clk); #1; gate = 1'b0;
    latch_now(a); wait_cyc(30); latch_now(b);
    check("R6 frozen count", int'(b), int'(a));
    check("R6 frozen out", int'(tmr_out), 1);
    @(posedge clk); #1; gate = 1'b1;
    latch_now(a); wait_cyc(3 * DIV - 2); latch_now(b);
    check("R6 resumed count", int'(a) - int'(b), 3);

    // zero means 65536
    load_latch(1'b0, 16'd0, a);
    check("R5 zero load reads 0", int'(a), 0);
    wait_cyc(2 * DIV - 2); latch_now(b);
    check("R5 after two ticks", int'(b), 65534);

    // immediate restart and mode change
    load_latch(1'b0, 16'd1000, a);
    wait_cyc(40);
    load_latch(1'b0, 16'd4, a);
    check("R7 immediate restart", int'(a), 4);
    run_periods(1'b0, 4, 3, "R7 rate N=4 after reload");
    load_latch(1'b1, 16'd8, a);
    run_periods(1'b1, 8, 3, "R7 mode switch square N=8");

    // load colliding with rate terminal-count reload
    load_latch(1'b0, 16'd3, a);
    begin
      logic seen = 1'b1;
      forever begin
        @(negedge clk);
        if (seen && !tmr_out) break;
        seen = tmr_out;
      end
    end
    repeat (DIV - 1) @(posedge clk);
    #1; ld_valid = 1'b1; ld_mode = 1'b0; ld_count = 16'd5;
    sb_q.delete(); skip = 2;
    @(posedge clk); #1; ld_valid = 1'b0; latch_strobe = 1'b1;
    @(posedge clk); #1; latch_strobe = 1'b0;
    @(negedge clk);
    check("R7 load beats terminal count", int'(rd_count), 5);
    check("R7 out high after collision", int'(tmr_out), 1);
    run_periods(1'b0, 5, 2, "R7 R2 after collision");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule